// File: doc/BRIEF.md
# I2C bus condition monitor

This block watches the clock and data lines of a two-wire I2C bus and recognises the three bus conditions a master has to track: START, repeated START and STOP. Both lines pass through a chain of synchronising flip-flops first, and every decision is made on the synchronised copies. A START is a falling data line while the clock line is high. A STOP is a rising data line while the clock line is high. Data movement while the clock line is low is normal bit traffic and is ignored.

Two sticky status bits record which condition came last. `start_seen` is set by a START and cleared by a STOP. `stop_seen` is set by a STOP and cleared by a START. A master may take the bus when `stop_seen` is set, or when neither bit has been set since reset or since the module was last enabled. The block drives that decision on `bus_free`.

Every detected condition sets one shared interrupt flag. The flag stays set until software sends a one-cycle clear pulse. The interrupt output is the flag gated by an interrupt-enable input. For each condition the block also gives a one-cycle event pulse, so an attached controller can tell which condition occurred.

Top module: `i2c_cond_mon`

## Requirements
- R1: After reset, `start_seen`, `stop_seen` and `irq_flag` are 0, `bus_free` is 1, and no event pulse is active.
- R2: While `enable` is 1, a falling synchronised SDA while synchronised SCL is high (START) sets `start_seen`, clears `stop_seen`, sets `irq_flag` and gives one `start_evt` pulse.
- R3: While `enable` is 1, a rising synchronised SDA while synchronised SCL is high (STOP) sets `stop_seen`, clears `start_seen`, sets `irq_flag` and gives one `stop_evt` pulse.
- R4: A START detected while `start_seen` is already 1 is a repeated START. It gives one `rstart_evt` pulse together with `start_evt`, sets `irq_flag`, and `start_seen` stays 1.
- R5: SDA changes while SCL is low change none of `start_seen`, `stop_seen`, `irq_flag`, and they give no event pulse.
- R6: `bus_free` is 1 when `stop_seen` is 1 or when both status bits are 0. `start_seen` and `stop_seen` are never 1 together.
- R7: While `enable` is 0, the status bits and `irq_flag` are held at 0, and bus conditions give no event pulse and no interrupt.
- R8: `irq_flag` stays 1 until a one-cycle `irq_clr` pulse clears it. If a clear and a new condition fall in the same cycle, the flag stays 1.
- R9: `irq` equals `irq_flag` when `irq_en` is 1 and is 0 when `irq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; 0 clears status and stops detection |
| irq_en | input | 1 | Interrupt output enable |
| irq_clr | input | 1 | One-cycle pulse that clears the interrupt flag |
| scl_in | input | 1 | Sampled bus clock line, asynchronous |
| sda_in | input | 1 | Sampled bus data line, asynchronous |
| start_seen | output | 1 | Sticky: last condition was a START |
| stop_seen | output | 1 | Sticky: last condition was a STOP |
| bus_free | output | 1 | A master may take the bus |
| irq_flag | output | 1 | Sticky condition interrupt flag |
| irq | output | 1 | Interrupt request, flag gated by irq_en |
| start_evt | output | 1 | One-cycle pulse on any START |
| rstart_evt | output | 1 | One-cycle pulse on a repeated START |
| stop_evt | output | 1 | One-cycle pulse on a STOP |

## Verification
The assertions assume that SCL and SDA never change in the same clock cycle and that each line level lasts longer than the synchroniser chain. Without this, one transition could hide another, or a START and a STOP could be judged from one pair of samples. The stimulus only moves one line per step and holds every level for several cycles. Software clears come as single-cycle pulses. The same-cycle race between a clear and a new condition is placed on purpose at the detection cycle.

// File: rtl/i2c_cond_mon.sv
module i2c_cond_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic irq_en,
  input  logic irq_clr,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_free,
  output logic irq_flag,
  output logic irq,
  output logic start_evt,
  output logic rstart_evt,
  output logic stop_evt
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sync, sda_sync;
  logic          scl_prev, sda_prev;
  logic          scl_now, sda_now;
  logic          start_det, stop_det;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= scl_in;
          sda_sync <= sda_in;
        end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= {scl_sync[LAST-1:0], scl_in};
          sda_sync <= {sda_sync[LAST-1:0], sda_in};
        end
    end
  endgenerate

  assign scl_now = scl_sync[LAST];
  assign sda_now = sda_sync[LAST];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_now;
      sda_prev <= sda_now;
    end

  assign start_det = enable & scl_now & scl_prev &  sda_prev & ~sda_now;
  assign stop_det  = enable & scl_now & scl_prev & ~sda_prev &  sda_now;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      irq_flag   <= 1'b0;
      start_evt  <= 1'b0;
      rstart_evt <= 1'b0;
      stop_evt   <= 1'b0;
    end else begin
      start_evt  <= start_det;
      rstart_evt <= start_det & start_seen;
      stop_evt   <= stop_det;
      if (!enable) begin
        start_seen <= 1'b0;
        stop_seen  <= 1'b0;
        irq_flag   <= 1'b0;
      end else begin
        if (start_det) begin
          start_seen <= 1'b1;
          stop_seen  <= 1'b0;
        end else if (stop_det) begin
          start_seen <= 1'b0;
          stop_seen  <= 1'b1;
        end
        if (start_det | stop_det) irq_flag <= 1'b1;
        else if (irq_clr)         irq_flag <= 1'b0;
      end
    end

  assign bus_free = stop_seen | ~start_seen;
  assign irq      = irq_flag & irq_en;

endmodule

// File: rtl/i2c_cond_mon_chk.sv
module i2c_cond_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic irq_clr,
  input logic start_seen,
  input logic stop_seen,
  input logic irq_flag,
  input logic start_evt,
  input logic rstart_evt,
  input logic stop_evt
);

  assert_start_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> start_seen && !stop_seen);

  assert_stop_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |-> stop_seen && !start_seen);

  assert_rstart_prior_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_evt |-> start_evt && $past(start_seen));

  assert_status_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));

  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !start_seen && !stop_seen && !irq_flag && !start_evt && !stop_evt);

  assert_flag_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(irq_clr) || !$past(enable));

  assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> start_evt || stop_evt);

endmodule

bind i2c_cond_mon i2c_cond_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .irq_clr(irq_clr),
  .start_seen(start_seen), .stop_seen(stop_seen), .irq_flag(irq_flag),
  .start_evt(start_evt), .rstart_evt(rstart_evt), .stop_evt(stop_evt)
);

// File: tb/test_i2c_cond_mon.sv
`timescale 1ns/1ps
module test_i2c_cond_mon;

  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic start_seen, stop_seen, bus_free, irq_flag, irq;
  logic start_evt, rstart_evt, stop_evt;

  int checks = 0, fails = 0;
  int n_st = 0, n_rs = 0, n_sp = 0;
  int e_st = 0, e_rs = 0, e_sp = 0;
  bit exp_s = 0, exp_p = 0, exp_f = 0, done = 0;

  always #10 clk = ~clk;

  i2c_cond_mon i_i2c_cond_mon (
    .clk(clk), .rst_n(rst_n), .enable(enable), .irq_en(irq_en), .irq_clr(irq_clr),
    .scl_in(scl_in), .sda_in(sda_in), .start_seen(start_seen), .stop_seen(stop_seen),
    .bus_free(bus_free), .irq_flag(irq_flag), .irq(irq), .start_evt(start_evt),
    .rstart_evt(rstart_evt), .stop_evt(stop_evt)
  );

  always @(posedge clk) if (rst_n) begin
    if (start_evt)  n_st++;
    if (rstart_evt) n_rs++;
    if (stop_evt)   n_sp++;
  end

  function automatic bit exp_free(bit s, bit p);
    return p | (~s & ~p);
  endfunction

  function automatic bit exp_irq(bit f, bit en);
    return f & en;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " start_seen"}, start_seen, exp_s);
    chk({req, " stop_seen"}, stop_seen, exp_p);
    chk({req, " irq_flag"}, irq_flag, exp_f);
    chk("R6 bus_free", bus_free, exp_free(exp_s, exp_p));
    chk("R9 irq", irq, exp_irq(exp_f, irq_en));
    chk({req, " start count"}, n_st, e_st);
    chk({req, " rstart count"}, n_rs, e_rs);
    chk({req, " stop count"}, n_sp, e_sp);
  endtask

  task automatic wait_hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic set_scl(bit v);
    if (scl_in != v) begin scl_in = v; wait_hold(); end
  endtask

  task automatic set_sda(bit v);
    if (sda_in != v) begin sda_in = v; wait_hold(); end
  endtask

  task automatic model_start();
    if (enable) begin
      if (exp_s) e_rs++;
      e_st++; exp_s = 1; exp_p = 0; exp_f = 1;
    end
  endtask

  task automatic model_stop();
    if (enable) begin
      e_sp++; exp_s = 0; exp_p = 1; exp_f = 1;
    end
  endtask

  task automatic bus_start();
    set_scl(0); set_sda(1); set_scl(1); set_sda(0);
    model_start();
  endtask

  task automatic bus_stop();
    set_scl(0); set_sda(0); set_scl(1); set_sda(1);
    model_stop();
  endtask

  task automatic bus_noise(int n);
    set_scl(0);
    for (int i = 0; i < n; i++) set_sda(~sda_in);
  endtask

  task automatic pulse_clr();
    irq_clr = 1; @(negedge clk); irq_clr = 0; @(negedge clk);
    if (enable) exp_f = 0;
  endtask

  task automatic set_enable(bit v);
    enable = v; @(negedge clk); @(negedge clk);
    if (!v) begin exp_s = 0; exp_p = 0; exp_f = 0; end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    check_all("R1 reset");
    chk("R1 bus_free", bus_free, 1);

    set_enable(1); irq_en = 1; @(negedge clk);
    bus_start();  check_all("R2 start");
    bus_noise(3); check_all("R5 noise");
    bus_start();  check_all("R4 repeated start");
    pulse_clr();  check_all("R8 clear");
    bus_stop();   check_all("R3 stop");
    irq_en = 0; @(negedge clk); check_all("R9 gated");
    irq_en = 1;
    bus_start(); set_enable(0); check_all("R7 disable clears");
    bus_stop(); bus_start(); check_all("R7 disabled ignores");
    set_enable(1);

    // R8: clear pulse in the detection cycle; the event must win
    set_scl(0); set_sda(1); set_scl(1);
    pulse_clr();
    bus_stop();
    set_scl(0); set_sda(1); set_scl(1);
    chk("R8 flag before race", irq_flag, exp_f);
    sda_in = 0; @(negedge clk); @(negedge clk);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    model_start();
    wait_hold();
    check_all("R8 clear race");

    for (int k = 0; k < 300; k++) begin
      case ($urandom_range(0, 7))
        0, 1: bus_start();
        2, 3: bus_stop();
        4: bus_noise($urandom_range(1, 4));
        5: pulse_clr();
        6: set_enable($urandom_range(0, 3) != 0);
        default: begin irq_en = $urandom_range(0, 1); @(negedge clk); end
      endcase
      check_all("R2 R3 R4 R5 R7 R8 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule